// File: doc/BRIEF.md
# Clear-on-read Ethernet statistics counter bank

This block holds seven event counters for a 10/100 Ethernet MAC. Each counter counts one kind of event: receive packets with any error, receive packets with a bad CRC, receives lost to a data or status FIFO overrun, receive alignment errors, receive packets with symbol errors, oversized receive frames, and transmissions that end with no collision heartbeat. The MAC drives a one-cycle strobe for each event, and the matching counter advances by one without any action from software.

A host reads the counters through a simple port. It gives a one-cycle read strobe and a byte address. The selected value appears on the data output in the next cycle, and the counter goes back to zero as part of that same read. The counters are narrow on purpose, so each one raises a warning once its count reaches a fixed high bit. Software can then drain the counter before it wraps. A single summary output is the OR of the seven warnings.

Top module: `stat_bank`

## Requirements
- R1: Each event strobe `evt_i[k]` adds one to counter k in the cycle it is seen. The counter widths, in order k = 0..6, are 16, 8, 8, 8, 8, 4 and 4 bits. A counter that overflows wraps to zero; it does not saturate.
- R2: When `rd_en_i` is high with a mapped address, `rd_data_o` shows the counter value after the next rising edge, zero-extended to 16 bits. The counter is zero after that edge.
- R3: When a read and an event reach the same counter in the same cycle, the read returns the value before the event, and the counter is left at 1.
- R4: Counter k sits at byte address 0x60 + 4*k. In order k = 0..6 the counters are: errored receive packets, CRC errors, overrun misses, alignment errors, symbol errors, oversized frames, and missing heartbeat.
- R5: `warn_o[k]` is high while counter k is at or above 2^B, where B is 8, 4, 4, 4, 4, 2 and 2 for k = 0..6. It goes low once a read clears the counter.
- R6: `warn_any_o` is high exactly when at least one bit of `warn_o` is high.
- R7: A read at an address that is not mapped returns 0 and clears no counter. This covers addresses below 0x60, above 0x78, and addresses that are not a multiple of 4.
- R8: After reset, every counter, `rd_data_o`, `warn_o` and `warn_any_o` are zero.
- R9: `rd_data_o` holds its value in every cycle in which `rd_en_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| evt_i | input | 7 | One-cycle event strobes, bit k feeds counter k |
| rd_en_i | input | 1 | One-cycle read strobe |
| rd_addr_i | input | 8 | Byte address of the read |
| rd_data_o | output | 16 | Read data, valid the cycle after the strobe |
| warn_o | output | 7 | Per-counter high-count warnings |
| warn_any_o | output | 1 | OR of all warnings |

## Verification
The hardest case to reach is a read and an event hitting the same counter in the same cycle, because the clear and the increment then compete for one register. The random stimulus fires events at a high rate and reads often, so these collisions happen many times on every counter. Directed steps also force the case at a known count. Further directed runs drive a 4-bit and an 8-bit counter past their wrap point and through their warning threshold with no read in between. Other directed steps probe the addresses just outside the map and the unaligned ones.

// File: rtl/stat_bank_pkg.sv
package stat_bank_pkg;

  localparam int NUM_CNT = 7;

  // Counter width per slot
  function automatic int cnt_width(input int k);
    case (k)
      0:       return 16;
      5, 6:    return 4;
      default: return 8;
    endcase
  endfunction

  // Bit position at which the warning rises
  function automatic int warn_bit(input int k);
    case (k)
      0:       return 8;
      5, 6:    return 2;
      default: return 4;
    endcase
  endfunction

endpackage

// File: rtl/stat_addr_dec.sv
module stat_addr_dec #(
  parameter int               ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h60,
  parameter int               NUM_SLOT  = 7
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rd_en_i,
  input  logic [ADDR_W-1:0]   addr_i,
  output logic [NUM_SLOT-1:0] sel_o,
  output logic                hit_o
);

  localparam int IDX_W = ADDR_W - 2;

  logic [ADDR_W-1:0] offs;
  logic [IDX_W-1:0]  idx;
  logic              in_map;

  assign offs   = addr_i - BASE_ADDR;
  assign idx    = offs[ADDR_W-1:2];
  assign in_map = (addr_i >= BASE_ADDR) && (offs[1:0] == 2'b00)
                  && (32'(idx) < NUM_SLOT);
  assign hit_o  = rd_en_i && in_map;

  for (genvar k = 0; k < NUM_SLOT; k++) begin : g_sel
    assign sel_o[k] = hit_o && (32'(idx) == k);
  end

  AST_SEL_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_o)); // R4

  AST_SEL_NEEDS_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |-> (sel_o == '0)); // R7

endmodule

// File: rtl/stat_cnt.sv
module stat_cnt #(
  parameter int CNT_W  = 8,
  parameter int WARN_B = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              evt_i,
  input  logic              rd_sel_i,
  output logic [DATA_W-1:0] cnt_o,
  output logic              warn_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  // Next state: a read clears, but keeps a coincident event
  always_comb begin
    cnt_d = cnt_q;
    if (rd_sel_i)   cnt_d = {{(CNT_W-1){1'b0}}, evt_i};
    else if (evt_i) cnt_d = cnt_q + 1'b1;
  end

  assign cnt_en = rd_sel_i | evt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign warn_o = |cnt_q[CNT_W-1:WARN_B];

  always_comb begin
    cnt_o              = '0;
    cnt_o[CNT_W-1:0]   = cnt_q;
  end

  AST_INC_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i && !rd_sel_i) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1))); // R1

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!evt_i && !rd_sel_i) |=> $stable(cnt_q)); // R1

  AST_CLR_ON_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_sel_i && !evt_i) |=> (cnt_q == '0)); // R2

  AST_READ_COLLIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_sel_i && evt_i) |=> (cnt_q == CNT_W'(1))); // R3

  AST_WARN_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_sel_i |=> !warn_o); // R5

endmodule

// File: rtl/stat_bank.sv
module stat_bank
  import stat_bank_pkg::*;
#(
  parameter int               ADDR_W    = 8,
  parameter int               DATA_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h60
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_CNT-1:0] evt_i,
  input  logic               rd_en_i,
  input  logic [ADDR_W-1:0]  rd_addr_i,
  output logic [DATA_W-1:0]  rd_data_o,
  output logic [NUM_CNT-1:0] warn_o,
  output logic               warn_any_o
);

  logic [NUM_CNT-1:0] sel;
  logic               hit;
  logic [DATA_W-1:0]  cnt_val [NUM_CNT];
  logic [DATA_W-1:0]  rd_mux;
  logic [DATA_W-1:0]  rd_data_q, rd_data_d;

  stat_addr_dec #(
    .ADDR_W   (ADDR_W),
    .BASE_ADDR(BASE_ADDR),
    .NUM_SLOT (NUM_CNT)
  ) dec_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rd_en_i(rd_en_i),
    .addr_i (rd_addr_i),
    .sel_o  (sel),
    .hit_o  (hit)
  );

  for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
    stat_cnt #(
      .CNT_W (cnt_width(k)),
      .WARN_B(warn_bit(k)),
      .DATA_W(DATA_W)
    ) cnt_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .evt_i   (evt_i[k]),
      .rd_sel_i(sel[k]),
      .cnt_o   (cnt_val[k]),
      .warn_o  (warn_o[k])
    );
  end

  // AND-OR read mux over the one-hot select
  always_comb begin
    rd_mux = '0;
    for (int k = 0; k < NUM_CNT; k++) begin
      rd_mux = rd_mux | (cnt_val[k] & {DATA_W{sel[k]}});
    end
  end

  always_comb begin
    rd_data_d = rd_data_q;
    if (rd_en_i) rd_data_d = hit ? rd_mux : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_data_q <= '0;
    else if (rd_en_i) rd_data_q <= rd_data_d;
  end

  assign rd_data_o  = rd_data_q;
  assign warn_any_o = |warn_o;

  AST_BAD_ADDR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !hit) |=> (rd_data_o == '0)); // R7

  AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o)); // R9

  AST_WARN_SUMMARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warn_o == '0) |-> !warn_any_o); // R6

endmodule

// File: tb/stat_bank_tb_top.sv
`timescale 1ns/1ps
module stat_bank_tb_top;

  localparam int N = 7;

  logic          clk_i = 1'b0;
  logic          rst_ni;
  logic [N-1:0]  evt_i;
  logic          rd_en_i;
  logic [7:0]    rd_addr_i;
  logic [15:0]   rd_data_o;
  logic [N-1:0]  warn_o;
  logic          warn_any_o;

  int checks = 0;
  int errors = 0;
  int mdl [N];
  logic [15:0] last_rd = '0;

  always #2.5 clk_i = ~clk_i;

  stat_bank dut_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .evt_i     (evt_i),
    .rd_en_i   (rd_en_i),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o),
    .warn_o    (warn_o),
    .warn_any_o(warn_any_o)
  );

  function automatic int wid(input int k);
    if (k == 0) return 16;
    if (k >= 5) return 4;
    return 8;
  endfunction

  function automatic int wbit(input int k);
    if (k == 0) return 8;
    if (k >= 5) return 2;
    return 4;
  endfunction

  // R4 / R7: slot index for an address, -1 when unmapped
  function automatic int slot_of(input logic [7:0] a);
    if (a < 8'h60 || a > 8'h78 || a[1:0] != 2'b00) return -1;
    return int'((a - 8'h60) >> 2);
  endfunction

  function automatic logic [N-1:0] exp_warn();
    logic [N-1:0] w = '0;
    for (int k = 0; k < N; k++) w[k] = (mdl[k] >= (1 << wbit(k)));
    return w;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One cycle: drive at negedge, check after the rising edge
  task automatic step(input logic [N-1:0] ev, input logic rd, input logic [7:0] a);
    int s;
    string tag;
    @(negedge clk_i);
    evt_i = ev; rd_en_i = rd; rd_addr_i = a;
    s = rd ? slot_of(a) : -1;
    tag = "R9";
    if (rd) begin
      if (s < 0) begin
        last_rd = '0; tag = "R7";
      end else begin
        last_rd = 16'(mdl[s]);
        tag = ev[s] ? "R3" : "R2";
      end
    end
    for (int k = 0; k < N; k++) begin
      if (rd && s == k) mdl[k] = ev[k] ? 1 : 0;
      else if (ev[k])   mdl[k] = (mdl[k] + 1) % (1 << wid(k));
    end
    @(posedge clk_i);
    #1;
    check({tag, " read data"}, 32'(rd_data_o), 32'(last_rd));
    check("R5 warn", 32'(warn_o), 32'(exp_warn()));
    check("R6 summary", 32'(warn_any_o), 32'(|exp_warn()));
    evt_i = '0; rd_en_i = 1'b0;
  endtask

  task automatic read_slot(input int k);
    step('0, 1'b1, 8'(8'h60 + 4 * k));
  endtask

  initial begin : watchdog
    #(5ns * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h5eed_1234));
    for (int k = 0; k < N; k++) mdl[k] = 0;
    evt_i = '0; rd_en_i = 1'b0; rd_addr_i = '0;
    rst_ni = 1'b0;
    repeat (3) @(posedge clk_i);
    #1;
    // R8 reset state
    check("R8 rd_data", 32'(rd_data_o), 0);
    check("R8 warn", 32'(warn_o), 0);
    check("R8 summary", 32'(warn_any_o), 0);
    @(negedge clk_i); rst_ni = 1'b1;
    for (int k = 0; k < N; k++) read_slot(k);

    // R1 wrap of a 4-bit counter: 17 events leave 1
    repeat (17) step(7'b0100000, 1'b0, 8'h00);
    read_slot(5);
    check("R1 wrap 4-bit", 32'(rd_data_o), 1);
    // R1 wrap of an 8-bit counter: 257 events leave 1
    repeat (257) step(7'b0000010, 1'b0, 8'h00);
    read_slot(1);
    check("R1 wrap 8-bit", 32'(rd_data_o), 1);
    // R5 threshold on counter 6 (bit 2): low at 3, high at 4
    repeat (3) step(7'b1000000, 1'b0, 8'h00);
    check("R5 below threshold", 32'(warn_o[6]), 0);
    step(7'b1000000, 1'b0, 8'h00);
    check("R5 at threshold", 32'(warn_o[6]), 1);
    // R3 collision at a known count: returns 4, leaves 1
    step(7'b1000000, 1'b1, 8'h78);
    check("R3 old value", 32'(rd_data_o), 4);
    read_slot(6);
    check("R3 left at one", 32'(rd_data_o), 1);
    // R7 unmapped addresses leave counters alone
    repeat (5) step(7'b0001000, 1'b0, 8'h00);
    step('0, 1'b1, 8'h5c);
    step('0, 1'b1, 8'h7c);
    step('0, 1'b1, 8'h6d);
    step('0, 1'b1, 8'h6e);
    read_slot(3);
    check("R7 count kept", 32'(rd_data_o), 5);
    // R0 counter to its warning at bit 8
    repeat (256) step(7'b0000001, 1'b0, 8'h00);
    check("R5 16-bit warn", 32'(warn_o[0]), 1);
    read_slot(0);
    check("R4 slot0 value", 32'(rd_data_o), 256);

    // Random traffic
    for (int i = 0; i < 6000; i++) begin
      logic [N-1:0] ev;
      logic         rd;
      logic [7:0]   a;
      for (int k = 0; k < N; k++) ev[k] = ($urandom % 3) == 0;
      rd = ($urandom % 4) == 0;
      a = (($urandom % 10) < 8) ? 8'(8'h60 + 4 * ($urandom % 7)) : 8'($urandom);
      step(ev, rd, a);
    end
    for (int k = 0; k < N; k++) read_slot(k);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule